// File: doc/BRIEF.md
# Lane-wise element interleave unit

This block builds one wide destination vector by merging elements from two source vectors. Each 128-bit lane of the destination is filled from one half of the matching lane of each source. A select input chooses the lower or the upper 64 bits of every lane. Inside a lane the destination takes one element from the first source, then the element with the same index from the second source, and repeats this from the least significant end. The element size can be 8, 16, 32 or 64 bits. Data never moves across a lane boundary, so the result is not a flat zip of the full-width operands.

A width mode sets how the bits above the lowest lane are written:

- Preserve mode keeps those bits from the prior destination value. In this mode the prior destination also serves as the first source.
- Zero-upper mode clears those bits.
- Full-width mode computes every lane independently.

An operation begins with a one-cycle start strobe. The result appears in a register together with a one-cycle valid pulse.

Top module: `lane_interleave_unit`

## Requirements
- R1: With element size code 0 (8-bit), destination byte 2i of a lane equals byte i of the chosen half of the first source, and byte 2i+1 equals byte i of the chosen half of the second source, counting from the least significant byte.
- R2: Element size codes 1, 2 and 3 select 16-, 32- and 64-bit elements with the same alternating order. With code 3, the lower 64 bits of a lane carry the first source's chosen quadword and the upper 64 bits carry the second source's.
- R3: With hi_sel_i = 0, each lane draws only from bits [63:0] of that lane of each source. The upper 64 bits of each source lane have no effect on the result.
- R4: With hi_sel_i = 1, each lane draws only from bits [127:64] of that lane of each source. In the default configuration this means bits 127:64 for lane 0 and bits 255:192 for lane 1.
- R5: With mode code 2 (full width), and with the reserved code 3 treated the same way, result bits above bit 127 come only from the sources' bits above bit 127. Each lane is interleaved on its own.
- R6: With mode code 0 (preserve), dest_old_i takes the place of src_a_i as the first source, and result bits above bit 127 equal dest_old_i's bits above bit 127.
- R7: With mode code 1 (zero upper), result bits above bit 127 are zero. The lowest lane is interleaved normally.
- R8: An element size code from 4 to 7 gives an all-zero result in every mode, and valid_o still pulses.
- R9: valid_o is high for exactly the one cycle after each cycle in which start_i is high. result_o keeps its value until the next start.
- R10: A synchronous active-high reset clears result_o and valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins an operation in this cycle |
| hi_sel_i | input | 1 | 1 selects the upper half of each lane, 0 the lower half |
| esize_i | input | 3 | Element size: 0=8, 1=16, 2=32, 3=64 bits; 4..7 invalid |
| mode_i | input | 2 | Width mode: 0 preserve, 1 zero upper, 2 or 3 full width |
| src_a_i | input | DATA_W | First source, used outside preserve mode |
| src_b_i | input | DATA_W | Second source |
| dest_old_i | input | DATA_W | Prior destination value, used in preserve mode |
| result_o | output | DATA_W | Registered interleaved result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the block with DATA_W = 256 and LANE_W = 128. These are the smallest values that give two lanes, so both the lane boundary and the handling of the upper part can be observed. Every combination of half select, element size code and mode code runs on random operands against a behavioural model. Directed operands cover two specific cases: changes confined to the unused half of a lane, and a reset applied while a result is being held.

// File: rtl/lil_pkg.sv
package lil_pkg;
   localparam logic [1:0] MODE_PRESERVE = 2'd0;
   localparam logic [1:0] MODE_ZERO_UP  = 2'd1;
   localparam logic [1:0] MODE_FULL     = 2'd2;
   localparam int         NUM_ESIZE     = 4;
   localparam int         MIN_ELEM_W    = 8;
   localparam int         MAX_ELEM_W    = MIN_ELEM_W << (NUM_ESIZE - 1);

   function automatic logic esize_ok(input logic [2:0] code);
      return code < 3'(NUM_ESIZE);
   endfunction
endpackage

// File: rtl/lil_lane_zip.sv
module lil_lane_zip
   import lil_pkg::*;
#(
   parameter int HALF_W = 64
) (
   input  logic [HALF_W-1:0]   first_i,
   input  logic [HALF_W-1:0]   second_i,
   input  logic [2:0]          esize_i,
   output logic [2*HALF_W-1:0] zip_o
);
   if (HALF_W % MAX_ELEM_W != 0)
      $error("lil_lane_zip: HALF_W must be a multiple of the largest element width");

   logic [NUM_ESIZE-1:0][2*HALF_W-1:0] variant;

   for (genvar s = 0; s < NUM_ESIZE; s++) begin : g_size
      localparam int EW = MIN_ELEM_W << s;
      localparam int NE = HALF_W / EW;
      for (genvar e = 0; e < NE; e++) begin : g_elem
         assign variant[s][(2*e)*EW   +: EW] = first_i[e*EW +: EW];
         assign variant[s][(2*e+1)*EW +: EW] = second_i[e*EW +: EW];
      end
   end

   always_comb begin
      zip_o = '0;
      if (esize_ok(esize_i))
         zip_o = variant[esize_i[1:0]];
   end
endmodule

// File: rtl/lil_upper_ctl.sv
module lil_upper_ctl
   import lil_pkg::*;
#(
   parameter int DATA_W = 256,
   parameter int LANE_W = 128
) (
   input  logic [DATA_W-1:0] zipped_i,
   input  logic [DATA_W-1:0] keep_i,
   input  logic [1:0]        mode_i,
   input  logic              size_ok_i,
   output logic [DATA_W-1:0] next_o
);
   always_comb begin
      next_o = zipped_i;
      if (!size_ok_i)
         next_o = '0;
      else if (mode_i == MODE_PRESERVE)
         next_o[DATA_W-1:LANE_W] = keep_i[DATA_W-1:LANE_W];
      else if (mode_i == MODE_ZERO_UP)
         next_o[DATA_W-1:LANE_W] = '0;
   end
endmodule

// File: rtl/lane_interleave_unit.sv
module lane_interleave_unit
   import lil_pkg::*;
#(
   parameter int DATA_W = 256,
   parameter int LANE_W = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              hi_sel_i,
   input  logic [2:0]        esize_i,
   input  logic [1:0]        mode_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic [DATA_W-1:0] dest_old_i,
   output logic [DATA_W-1:0] result_o,
   output logic              valid_o
);
   localparam int NUM_LANES = DATA_W / LANE_W;
   localparam int HALF_W    = LANE_W / 2;

   if (DATA_W % LANE_W != 0)
      $error("lane_interleave_unit: DATA_W must be a whole number of lanes");
   if (NUM_LANES < 2)
      $error("lane_interleave_unit: at least two lanes are required");

   logic [DATA_W-1:0] first_src;
   logic [DATA_W-1:0] zipped;
   logic [DATA_W-1:0] next_result;

   assign first_src = (mode_i == MODE_PRESERVE) ? dest_old_i : src_a_i;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [HALF_W-1:0] first_half;
      logic [HALF_W-1:0] second_half;

      assign first_half  = hi_sel_i ? first_src[l*LANE_W+HALF_W +: HALF_W]
                                    : first_src[l*LANE_W +: HALF_W];
      assign second_half = hi_sel_i ? src_b_i[l*LANE_W+HALF_W +: HALF_W]
                                    : src_b_i[l*LANE_W +: HALF_W];

      lil_lane_zip #(.HALF_W(HALF_W)) u_zip (
         .first_i  (first_half),
         .second_i (second_half),
         .esize_i  (esize_i),
         .zip_o    (zipped[l*LANE_W +: LANE_W])
      );
   end

   lil_upper_ctl #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_upper (
      .zipped_i  (zipped),
      .keep_i    (dest_old_i),
      .mode_i    (mode_i),
      .size_ok_i (esize_ok(esize_i)),
      .next_o    (next_result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= start_i;
         if (start_i)
            result_o <= next_result;
      end
   end
endmodule

// File: rtl/lil_checker.sv
module lil_checker
   import lil_pkg::*;
#(
   parameter int DATA_W = 256,
   parameter int LANE_W = 128
) (
   input logic              clk,
   input logic              rst,
   input logic              start_i,
   input logic              hi_sel_i,
   input logic [2:0]        esize_i,
   input logic [1:0]        mode_i,
   input logic [DATA_W-1:0] src_a_i,
   input logic [DATA_W-1:0] src_b_i,
   input logic [DATA_W-1:0] dest_old_i,
   input logic [DATA_W-1:0] result_o,
   input logic              valid_o
);
   localparam int HALF_W = LANE_W / 2;

   a_r9_valid_after_start: assert property (@(posedge clk) disable iff (rst)
      start_i |=> valid_o);

   a_r9_no_valid_without_start: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> !valid_o);

   a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> $stable(result_o));

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (!valid_o && result_o == '0));

   a_r8_bad_size_zero: assert property (@(posedge clk) disable iff (rst)
      (start_i && esize_i >= 3'(NUM_ESIZE)) |=> (valid_o && result_o == '0));

   a_r7_upper_cleared: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == MODE_ZERO_UP) |=> (result_o[DATA_W-1:LANE_W] == '0));

   a_r6_upper_kept: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == MODE_PRESERVE && esize_ok(esize_i))
      |=> (result_o[DATA_W-1:LANE_W] == $past(dest_old_i[DATA_W-1:LANE_W])));

   a_r2_quad_low_order: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == MODE_FULL && esize_i == 3'd3 && !hi_sel_i)
      |=> (result_o[HALF_W-1:0] == $past(src_a_i[HALF_W-1:0]) &&
           result_o[LANE_W-1:HALF_W] == $past(src_b_i[HALF_W-1:0])));

   a_r4_quad_high_lane1: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == MODE_FULL && esize_i == 3'd3 && hi_sel_i)
      |=> (result_o[LANE_W+HALF_W-1:LANE_W] == $past(src_a_i[2*LANE_W-1:LANE_W+HALF_W])));
endmodule

bind lane_interleave_unit lil_checker #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start_i    (start_i),
   .hi_sel_i   (hi_sel_i),
   .esize_i    (esize_i),
   .mode_i     (mode_i),
   .src_a_i    (src_a_i),
   .src_b_i    (src_b_i),
   .dest_old_i (dest_old_i),
   .result_o   (result_o),
   .valid_o    (valid_o)
);

// File: tb/lane_interleave_unit_tb_top.sv
module lane_interleave_unit_tb_top;
   localparam int DW = 256;
   localparam int LW = 128;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_i = 1'b0;
   logic          hi_sel_i = 1'b0;
   logic [2:0]    esize_i = 3'd0;
   logic [1:0]    mode_i = 2'd2;
   logic [DW-1:0] src_a_i = '0;
   logic [DW-1:0] src_b_i = '0;
   logic [DW-1:0] dest_old_i = '0;
   logic [DW-1:0] result_o;
   logic          valid_o;

   int     checks = 0;
   int     failures = 0;
   bit     armed = 1'b0;
   bit     done = 1'b0;
   string  cur_tag = "R10";
   string  exp_tag = "R10";
   logic [DW-1:0] exp_res = '0;
   logic          exp_val = 1'b0;

   always #2 clk = ~clk;

   lane_interleave_unit #(.DATA_W(DW), .LANE_W(LW)) dut_i (
      .clk(clk), .rst(rst), .start_i(start_i), .hi_sel_i(hi_sel_i),
      .esize_i(esize_i), .mode_i(mode_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
      .dest_old_i(dest_old_i), .result_o(result_o), .valid_o(valid_o)
   );

   function automatic logic [DW-1:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic [DW-1:0] old, input logic hi,
                                           input logic [2:0] es, input logic [1:0] md);
      logic [DW-1:0] r;
      logic [DW-1:0] s1;
      int ew;
      int cnt;
      int base;
      r = '0;
      if (es > 3'd3) return r;
      s1 = (md == 2'd0) ? old : a;
      ew = 8 << es;
      cnt = 64 / ew;
      for (int lane = 0; lane < 2; lane++) begin
         base = lane * 128 + (hi ? 64 : 0);
         for (int i = 0; i < cnt; i++)
            for (int bt = 0; bt < ew; bt++) begin
               r[lane*128 + 2*i*ew + bt]     = s1[base + i*ew + bt];
               r[lane*128 + (2*i+1)*ew + bt] = b[base + i*ew + bt];
            end
      end
      if (md == 2'd0) r[255:128] = old[255:128];
      if (md == 2'd1) r[255:128] = '0;
      return r;
   endfunction

   function automatic logic [DW-1:0] rnd();
      logic [DW-1:0] v;
      for (int k = 0; k < DW / 32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   // reference model, updated on each active edge
   always @(posedge clk) begin
      if (rst) begin
         exp_res <= '0;
         exp_val <= 1'b0;
         exp_tag <= "R10";
      end else begin
         exp_val <= start_i;
         exp_tag <= cur_tag;
         if (start_i)
            exp_res <= model(src_a_i, src_b_i, dest_old_i, hi_sel_i, esize_i, mode_i);
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (armed && !done) begin
         checks++;
         if (result_o !== exp_res) begin
            failures++;
            $display("FAIL %s result: actual=%h expected=%h", exp_tag, result_o, exp_res);
         end
         checks++;
         if (valid_o !== exp_val) begin
            failures++;
            $display("FAIL %s valid: actual=%b expected=%b", exp_tag, valid_o, exp_val);
         end
      end
   end

   task automatic op(input logic hi, input logic [2:0] es, input logic [1:0] md,
                     input string tag);
      @(negedge clk);
      cur_tag    = tag;
      hi_sel_i   = hi;
      esize_i    = es;
      mode_i     = md;
      src_a_i    = rnd();
      src_b_i    = rnd();
      dest_old_i = rnd();
      start_i    = 1'b1;
   endtask

   task automatic idle(input int n, input string tag);
      @(negedge clk);
      cur_tag = tag;
      start_i = 1'b0;
      src_a_i = rnd();
      src_b_i = rnd();
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R10: reset state
      @(negedge clk);
      armed = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // R1: byte interleave, lower halves, full width
      op(1'b0, 3'd0, 2'd2, "R1");
      op(1'b0, 3'd0, 2'd2, "R1");
      idle(2, "R9");
      // R2: wider elements
      for (int es = 1; es < 4; es++) begin
         op(1'b0, 3'(es), 2'd2, "R2");
         op(1'b1, 3'(es), 2'd2, "R2");
      end
      idle(1, "R9");
      // R3: upper halves changed, lower halves fixed
      op(1'b0, 3'd1, 2'd2, "R3");
      @(negedge clk);
      src_a_i[127:64] = ~src_a_i[127:64];
      src_b_i[255:192] = ~src_b_i[255:192];
      @(negedge clk);
      start_i = 1'b0;
      // R4: upper halves selected, lower halves scrambled between ops
      op(1'b1, 3'd0, 2'd3, "R4");
      @(negedge clk);
      src_a_i[63:0] = ~src_a_i[63:0];
      src_b_i[191:128] = ~src_b_i[191:128];
      @(negedge clk);
      start_i = 1'b0;
      // full sweep of every control combination
      for (int md = 0; md < 4; md++)
         for (int hi = 0; hi < 2; hi++)
            for (int es = 0; es < 8; es++) begin
               string t;
               if (es > 3) t = "R8";
               else if (md == 0) t = "R6";
               else if (md == 1) t = "R7";
               else t = "R5";
               op(1'(hi), 3'(es), 2'(md), t);
               if (es % 3 == 0) idle(2, "R9");
            end
      // R9: long hold without start
      op(1'b1, 3'd2, 2'd2, "R9");
      idle(6, "R9");
      // R10: reset while a result is held
      op(1'b0, 3'd3, 2'd0, "R10");
      @(negedge clk);
      start_i = 1'b0;
      cur_tag = "R10";
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      op(1'b1, 3'd0, 2'd1, "R7");
      idle(3, "R9");
      finish_run();
   end
endmodule